// File: doc/BRIEF.md
# Cyclic Audio Stream DMA Sequencer

This block is the per-stream engine of an audio stream controller. Software fills a small local table of buffer descriptors. Each descriptor holds a byte address, a length in bytes and a completion flag. Software then programs a handful of stream registers and sets the run bit. The engine walks the descriptors from a programmable base slot up to a programmable last index and then starts again at the first. For every data word it presents a byte address on a request/grant read port. It also keeps a link position counter that runs over the whole cyclic buffer and wraps back to zero.

When the last word of a descriptor whose completion flag is set has been granted, the engine sets a buffer-complete status bit. The bit stays set until software writes a one to it. A descriptor of zero length is treated as a fault: the engine sets a descriptor-error status bit and issues no further requests. The interrupt output combines the two status bits with their enables in the control byte. The register file also keeps the format word and the stream tag, so that the link side can read them.

Top module: `stream_dma_seq`

## Requirements
- R1: After reset, memReq and irq are 0, linkPos is 0, and every register reads back 0.
- R2: The control byte (address 0), format word (address 2), list base (address 3), last index (address 4) and cyclic length (address 5) read back as written. In the control byte, bit 0 is run, bit 1 is the completion interrupt enable, bit 2 is the FIFO-error enable, bit 3 is the descriptor-error enable, and bits 7:4 are the stream tag.
- R3: When run goes from 0 to 1, linkPos becomes 0 and the walk restarts at descriptor index 0. The first request address is that descriptor's address, and each grant advances the address by 4 bytes.
- R4: After the descriptor at the last index completes, the walk continues at index 0. Index i reads descriptor slot (base + i) modulo the table depth, so a last index of 0 repeats a single descriptor.
- R5: Each grant advances linkPos by 4. When the new value would reach or pass the cyclic length, linkPos becomes 0 instead.
- R6: Granting the final word of a descriptor whose completion flag is set sets status bit 0 (buffer complete) at the same clock edge. A descriptor whose flag is clear sets nothing.
- R7: The status bits at address 1 are write-1-to-clear. Writing 0 leaves a bit unchanged, and a new set event wins over a clear in the same cycle.
- R8: irq equals (status bit 0 AND the completion enable) OR (status bit 1 AND the descriptor-error enable).
- R9: Clearing run drops memReq from the next cycle. linkPos then holds its value until run is set again.
- R10: A descriptor of zero length sets status bit 1 (descriptor error). After that, memReq stays 0 until run is cleared and set again.
- R11: linkPos is readable at address 6, and writes to that address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| dscWe | input | 1 | Descriptor slot write strobe |
| dscIdx | input | 4 | Descriptor slot number |
| dscAddr | input | 32 | Descriptor buffer byte address |
| dscLen | input | 20 | Descriptor length in bytes (a multiple of 4) |
| dscIoc | input | 1 | Descriptor completion flag |
| memReq | output | 1 | Read request for one data word |
| memAddr | output | 32 | Byte address of the requested word |
| memGnt | input | 1 | Grant; the word is consumed at the clock edge |
| linkPos | output | 20 | Current position in the cyclic buffer, in bytes |
| irq | output | 1 | Stream interrupt |

## Verification
Some conditions are hard to reach from the ports. Examples are the wrap of the descriptor index and the wrap of linkPos landing on the same grant, a stop in the middle of a descriptor followed by a restart, and a zero-length descriptor met at fetch. The list used in the stimulus has three descriptors whose lengths add up exactly to the cyclic length. As a result, linkPos wraps on the same grant that ends the last descriptor, and the vector table covers more than one full cycle around the list. Directed runs then change the list base and last index so that a single repeating slot is used, stop and restart the stream between grants, and point the base at a zero-length slot to force the fault.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_HALT
  } seq_state_e;

  typedef struct packed {
    logic startRun;
    logic loadDesc;
    logic advWord;
    logic descEnd;
    logic descFault;
  } seq_strobe_t;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_FMT  = 3'd2;
  localparam logic [2:0] REG_BASE = 3'd3;
  localparam logic [2:0] REG_LAST = 3'd4;
  localparam logic [2:0] REG_CLEN = 3'd5;
  localparam logic [2:0] REG_LPOS = 3'd6;

endpackage

// File: rtl/sdma_desc_mem.sv
module sdma_desc_mem #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = ADDR_W + LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic              wrIoc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LEN_W-1:0]  rdLen,
  output logic              rdIoc
);

  logic [ENT_W-1:0] slotQ [DEPTH];
  logic [ENT_W-1:0] wrWord;
  logic [ENT_W-1:0] rdWord;

  assign wrWord = {wrAddr, wrLen, wrIoc};

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slotQ[e] <= '0;
      else if (wrEn && (wrIdx == IDX_W'(e)))
        slotQ[e] <= wrWord;
    end
  end

  assign rdWord = slotQ[rdIdx];
  assign rdAddr = rdWord[ENT_W-1 -: ADDR_W];
  assign rdLen  = rdWord[LEN_W:1];
  assign rdIoc  = rdWord[0];

endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int LEN_W = 20,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             doneSet,
  input  logic             errSet,
  input  logic [LEN_W-1:0] linkPos,
  output logic             runBit,
  output logic [IDX_W-1:0] listBase,
  output logic [IDX_W-1:0] lastIdx,
  output logic [LEN_W-1:0] cycLen,
  output logic             irq
);

  logic [7:0]  ctrlByte;
  logic [15:0] fmtWord;
  logic        stsDone;
  logic        stsErr;
  logic        wrStat;
  logic        unusedWrBits;

  assign wrStat       = regWe && (regAddr == REG_STAT);
  assign unusedWrBits = ^regWrData[31:LEN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlByte <= '0;
      fmtWord  <= '0;
      listBase <= '0;
      lastIdx  <= '0;
      cycLen   <= '0;
    end else if (regWe) begin
      case (regAddr)
        REG_CTRL: ctrlByte <= regWrData[7:0];
        REG_FMT:  fmtWord  <= regWrData[15:0];
        REG_BASE: listBase <= regWrData[IDX_W-1:0];
        REG_LAST: lastIdx  <= regWrData[IDX_W-1:0];
        REG_CLEN: cycLen   <= regWrData[LEN_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stsDone <= 1'b0;
      stsErr  <= 1'b0;
    end else begin
      stsDone <= doneSet | (stsDone & ~(wrStat & regWrData[0]));
      stsErr  <= errSet  | (stsErr  & ~(wrStat & regWrData[1]));
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: regRdData[7:0]       = ctrlByte;
      REG_STAT: regRdData[1:0]       = {stsErr, stsDone};
      REG_FMT:  regRdData[15:0]      = fmtWord;
      REG_BASE: regRdData[IDX_W-1:0] = listBase;
      REG_LAST: regRdData[IDX_W-1:0] = lastIdx;
      REG_CLEN: regRdData[LEN_W-1:0] = cycLen;
      REG_LPOS: regRdData[LEN_W-1:0] = linkPos;
      default:  regRdData            = '0;
    endcase
  end

  assign runBit = ctrlByte[0];
  assign irq    = (stsDone & ctrlByte[1]) | (stsErr & ctrlByte[3]);

  // R7: a one written to bit 0, with no set event, clears it
  p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStat && regWrData[0] && !doneSet) |=> !stsDone);

  // R7: a zero written to bit 0 keeps it
  p_w1c_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStat && !regWrData[0] && stsDone) |=> stsDone);

  // R6: a completion event is visible on the next cycle
  p_done_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    doneSet |=> stsDone);

  // R10: a fault is visible on the next cycle
  p_err_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    errSet |=> stsErr);

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        runBit,
  input  logic        memGnt,
  input  logic        lenZero,
  input  logic        lastWord,
  output seq_strobe_t strb,
  output logic        memReq
);

  seq_state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (runBit) begin
          strb.startRun = 1'b1;
          stateD        = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (!runBit) begin
          stateD = ST_IDLE;
        end else if (lenZero) begin
          strb.descFault = 1'b1;
          stateD         = ST_HALT;
        end else begin
          strb.loadDesc = 1'b1;
          stateD        = ST_XFER;
        end
      end
      ST_XFER: begin
        if (!runBit) begin
          stateD = ST_IDLE;
        end else if (memGnt) begin
          strb.advWord = 1'b1;
          if (lastWord) begin
            strb.descEnd = 1'b1;
            stateD       = ST_FETCH;
          end
        end
      end
      ST_HALT: begin
        if (!runBit) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  assign memReq = (stateQ == ST_XFER) && runBit;

  // R9: no request while run is clear
  p_stop_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !runBit |-> !memReq);

  // R10: a faulted stream issues nothing
  p_halt_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_HALT) |-> !memReq);

  // R10: a fault leads to halt or, if run dropped, to idle
  p_fault_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.descFault |=> (stateQ == ST_HALT || stateQ == ST_IDLE));

endmodule

// File: rtl/sdma_datapath.sv
module sdma_datapath
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       strb,
  input  logic [IDX_W-1:0]  listBase,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic [LEN_W-1:0]  cycLen,
  output logic [IDX_W-1:0]  slotIdx,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [LEN_W-1:0]  dLen,
  input  logic              dIoc,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  linkPos,
  output logic              lenZero,
  output logic              lastWord,
  output logic              doneSet
);

  localparam logic [LEN_W-1:0]  STEP_LEN  = LEN_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(WORD_BYTES);

  logic [IDX_W-1:0]  descIdx;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;
  logic              curIoc;
  logic [LEN_W:0]    posNext;

  assign slotIdx  = listBase + descIdx;
  assign lenZero  = (dLen == '0);
  assign lastWord = (remain <= STEP_LEN);
  assign doneSet  = strb.descEnd & curIoc;
  assign memAddr  = curAddr;
  assign posNext  = {1'b0, linkPos} + {1'b0, STEP_LEN};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      descIdx <= '0;
      curAddr <= '0;
      remain  <= '0;
      curIoc  <= 1'b0;
      linkPos <= '0;
    end else begin
      if (strb.startRun) begin
        descIdx <= '0;
        linkPos <= '0;
      end
      if (strb.loadDesc) begin
        curAddr <= dAddr;
        remain  <= dLen;
        curIoc  <= dIoc;
      end
      if (strb.advWord) begin
        curAddr <= curAddr + STEP_ADDR;
        remain  <= remain - STEP_LEN;
        linkPos <= (posNext >= {1'b0, cycLen}) ? '0 : posNext[LEN_W-1:0];
      end
      if (strb.descEnd)
        descIdx <= (descIdx == lastIdx) ? '0 : descIdx + 1'b1;
    end
  end

  // R3: a start clears the position and the index
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.startRun |=> (linkPos == '0 && descIdx == '0));

  // R4: ending the last descriptor returns to index 0
  p_index_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.descEnd && descIdx == lastIdx) |=> (descIdx == '0));

  // R5: each grant steps the position by one word or wraps it
  p_pos_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.advWord |=> (linkPos == '0 || linkPos == $past(linkPos) + STEP_LEN));

  // R9: no position change without a grant or a start
  p_pos_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.advWord && !strb.startRun) |=> $stable(linkPos));

endmodule

// File: rtl/stream_dma_seq.sv
module stream_dma_seq
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int DESC_DEPTH = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(DESC_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              dscWe,
  input  logic [IDX_W-1:0]  dscIdx,
  input  logic [ADDR_W-1:0] dscAddr,
  input  logic [LEN_W-1:0]  dscLen,
  input  logic              dscIoc,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  output logic [LEN_W-1:0]  linkPos,
  output logic              irq
);

  seq_strobe_t       strb;
  logic              runBit;
  logic [IDX_W-1:0]  listBase;
  logic [IDX_W-1:0]  lastIdx;
  logic [LEN_W-1:0]  cycLen;
  logic [IDX_W-1:0]  slotIdx;
  logic [ADDR_W-1:0] dAddr;
  logic [LEN_W-1:0]  dLen;
  logic              dIoc;
  logic              lenZero;
  logic              lastWord;
  logic              doneSet;

  sdma_regs #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .doneSet(doneSet),
    .errSet(strb.descFault), .linkPos(linkPos), .runBit(runBit),
    .listBase(listBase), .lastIdx(lastIdx), .cycLen(cycLen), .irq(irq)
  );

  sdma_desc_mem #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DESC_DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wrEn(dscWe), .wrIdx(dscIdx), .wrAddr(dscAddr),
    .wrLen(dscLen), .wrIoc(dscIoc), .rdIdx(slotIdx), .rdAddr(dAddr),
    .rdLen(dLen), .rdIoc(dIoc)
  );

  sdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .runBit(runBit), .memGnt(memGnt),
    .lenZero(lenZero), .lastWord(lastWord), .strb(strb), .memReq(memReq)
  );

  sdma_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
                  .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .listBase(listBase),
    .lastIdx(lastIdx), .cycLen(cycLen), .slotIdx(slotIdx), .dAddr(dAddr),
    .dLen(dLen), .dIoc(dIoc), .memAddr(memAddr), .linkPos(linkPos),
    .lenZero(lenZero), .lastWord(lastWord), .doneSet(doneSet)
  );

endmodule

// File: tb/tb_stream_dma_seq.sv
module tb_stream_dma_seq;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [19:0] pos;
    logic        irqAfter;
  } vec_t;

  // main list: slot0 0x100/8/no flag, slot1 0x200/4/flag, slot2 0x300/8/flag, length 20
  localparam vec_t VECS [0:7] = '{
    '{32'h100, 20'd0,  1'b0},
    '{32'h104, 20'd4,  1'b0},
    '{32'h200, 20'd8,  1'b1},
    '{32'h300, 20'd12, 1'b0},
    '{32'h304, 20'd16, 1'b1},
    '{32'h100, 20'd0,  1'b0},
    '{32'h104, 20'd4,  1'b0},
    '{32'h200, 20'd8,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        dscWe = 1'b0;
  logic [3:0]  dscIdx = '0;
  logic [31:0] dscAddr = '0;
  logic [19:0] dscLen = '0;
  logic        dscIoc = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memGnt = 1'b0;
  logic [19:0] linkPos;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [31:0] rv;

  stream_dma_seq dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dscWe(dscWe),
    .dscIdx(dscIdx), .dscAddr(dscAddr), .dscLen(dscLen), .dscIoc(dscIoc),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt), .linkPos(linkPos),
    .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWrData = d;
    step();
    regWe = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic dw(input logic [3:0] i, input logic [31:0] a,
                    input logic [19:0] l, input logic f);
    dscWe = 1'b1; dscIdx = i; dscAddr = a; dscLen = l; dscIoc = f;
    step();
    dscWe = 1'b0;
  endtask

  task automatic grant(input logic [31:0] ea, input logic [19:0] ep,
                       input logic ei, input string tag);
    for (int n = 0; n < 50 && !memReq; n++) step();
    chk(memReq == 1'b1, {tag, " req"}, 32'(memReq), 32'd1);
    chk(memAddr == ea, {tag, " addr"}, memAddr, ea);
    chk(linkPos == ep, {tag, " pos"}, 32'(linkPos), 32'(ep));
    memGnt = 1'b1;
    step();
    memGnt = 1'b0;
    chk(irq == ei, {tag, " irq"}, 32'(irq), 32'(ei));
  endtask

  initial begin
    repeat (3) step();
    // R1: reset state
    chk(memReq == 1'b0, "R1 memReq", 32'(memReq), 32'd0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
    chk(linkPos == '0, "R1 linkPos", 32'(linkPos), 32'd0);
    rd(3'd0, rv); chk(rv == 32'd0, "R1 ctrl", rv, 32'd0);
    rd(3'd1, rv); chk(rv == 32'd0, "R1 status", rv, 32'd0);
    rd(3'd5, rv); chk(rv == 32'd0, "R1 cyclen", rv, 32'd0);
    rst_n = 1'b1;
    step();

    // R2: readback, tag 0xA in bits 7:4, enables 1 and 2
    wr(3'd0, 32'hA6); rd(3'd0, rv); chk(rv == 32'hA6, "R2 ctrl", rv, 32'hA6);
    wr(3'd2, 32'h4011); rd(3'd2, rv); chk(rv == 32'h4011, "R2 fmt", rv, 32'h4011);
    wr(3'd3, 32'd9); rd(3'd3, rv); chk(rv == 32'd9, "R2 base", rv, 32'd9);
    wr(3'd4, 32'd2); rd(3'd4, rv); chk(rv == 32'd2, "R2 last", rv, 32'd2);
    wr(3'd5, 32'd20); rd(3'd5, rv); chk(rv == 32'd20, "R2 cyclen", rv, 32'd20);
    // R11: link position register ignores writes
    wr(3'd6, 32'h44); rd(3'd6, rv); chk(rv == 32'd0, "R11 lpos", rv, 32'd0);
    wr(3'd0, 32'h00);

    dw(4'd0, 32'h100, 20'd8, 1'b0);
    dw(4'd1, 32'h200, 20'd4, 1'b1);
    dw(4'd2, 32'h300, 20'd8, 1'b1);
    dw(4'd4, 32'h400, 20'd4, 1'b0);
    dw(4'd6, 32'h600, 20'd0, 1'b0);
    wr(3'd3, 32'd0);

    // R3 R4 R5 R6 R8: vector walk, tag 5, completion and error enables, run
    wr(3'd0, 32'h5B);
    for (int v = 0; v < 8; v++) begin
      grant(VECS[v].addr, VECS[v].pos, VECS[v].irqAfter, $sformatf("R5 vec%0d", v));
      if (VECS[v].irqAfter) begin
        wr(3'd1, 32'd1);
        chk(irq == 1'b0, "R7 clear", 32'(irq), 32'd0);
      end
    end

    // R9: stop mid-list, position holds
    grant(32'h300, 20'd12, 1'b0, "R9 pre");
    wr(3'd0, 32'h5A);
    chk(memReq == 1'b0, "R9 req drop", 32'(memReq), 32'd0);
    repeat (4) step();
    chk(memReq == 1'b0, "R9 req idle", 32'(memReq), 32'd0);
    chk(linkPos == 20'd16, "R9 hold", 32'(linkPos), 32'd16);

    // R3: restart from descriptor 0 at position 0
    wr(3'd0, 32'h5B);
    grant(32'h100, 20'd0, 1'b0, "R3 restart");
    wr(3'd0, 32'h5A);

    // R8 R6 R7: completion enable cleared
    wr(3'd0, 32'h59);
    grant(32'h100, 20'd0, 1'b0, "R8 m0");
    grant(32'h104, 20'd4, 1'b0, "R6 noflag");
    rd(3'd1, rv); chk(rv == 32'd0, "R6 noflag status", rv, 32'd0);
    grant(32'h200, 20'd8, 1'b0, "R8 masked");
    rd(3'd1, rv); chk(rv == 32'd1, "R6 status set", rv, 32'd1);
    wr(3'd1, 32'd0);
    rd(3'd1, rv); chk(rv == 32'd1, "R7 zero write", rv, 32'd1);
    wr(3'd1, 32'd1);
    rd(3'd1, rv); chk(rv == 32'd0, "R7 one write", rv, 32'd0);
    wr(3'd0, 32'h58);

    // R4: base 4, last index 0, single repeating slot; R5 wrap at length 4
    wr(3'd3, 32'd4); wr(3'd4, 32'd0); wr(3'd5, 32'd4);
    wr(3'd0, 32'h5B);
    grant(32'h400, 20'd0, 1'b0, "R4 first");
    grant(32'h400, 20'd0, 1'b0, "R4 repeat");
    wr(3'd0, 32'h5A);

    // R10: zero-length slot faults
    wr(3'd3, 32'd6);
    wr(3'd0, 32'h5B);
    repeat (6) step();
    chk(memReq == 1'b0, "R10 no req", 32'(memReq), 32'd0);
    rd(3'd1, rv); chk(rv == 32'd2, "R10 status", rv, 32'd2);
    chk(irq == 1'b1, "R10 irq", 32'(irq), 32'd1);
    wr(3'd0, 32'h5A);
    wr(3'd1, 32'd2);
    chk(irq == 1'b0, "R10 cleared", 32'(irq), 32'd0);

    finish_run();
  end

endmodule